// File: doc/BRIEF.md
# Delay-Line Address Programming Interface

This block turns host pin activity into the address that selects a tap of a programmable delay line. A mode pin picks the way the address is set. With the mode pin high and the enable held high, the parallel pins pass straight through to the address. With the mode pin high and the enable pulsed, the parallel value is captured when the enable falls. With the mode pin low, bits are shifted into an input register on rising edges of a serial clock while the enable is high. The new value takes effect only when the enable falls.

All pins are asynchronous to the system clock. Each pin is brought into the clock domain through a synchronizer chain of parameter depth, and edges are found on the synchronized copies. While a serial transfer is open, the serial output shows the bit leaving the input register, most significant bit first. Devices can therefore be chained output-to-input, and a host can read the register back. A read replaces the register contents, so a host that wants to keep the setting shifts the read value back in.

Top module: `dly_prog_if`

## Requirements
- R1: After reset the active address is 0, the serial output is 0 and its output enable is 0.
- R2: With mode 1 (parallel) and the enable high, the active address follows the parallel pins.
- R3: With mode 1 and the enable low, changes on the parallel pins do not alter the active address. The value present when the enable fell is kept.
- R4: With mode 0 (serial), shifting does not alter the active address before the enable falls.
- R5: With mode 0, the falling edge of the enable copies the input register into the active address.
- R6: With mode 0 and the enable high, the serial output shows the previous register contents, bit 7 first. Each serial clock rising edge shifts the serial input into bit 0 and exposes the next lower old bit.
- R7: With mode 0 and the enable low, serial clock edges do not shift the input register.
- R8: Sixteen bits shifted into a single device bring the first eight bits back out on the serial output. This is the cascade behaviour.
- R9: A read that is not written back is destructive: the shifted-in bits become the address when the enable falls.
- R10: The serial output enable is 1 only in mode 0 with the enable high. Otherwise the serial output and its enable are 0.
- R11: A parallel load also loads the input register, so a following serial read returns the parallel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 1 = parallel modes, 0 = serial mode (asynchronous) |
| en_i | input | 1 | Address enable (asynchronous) |
| par_i | input | ADDR_W | Parallel address bits (asynchronous) |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| addr_o | output | ADDR_W | Active delay address |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial output drive enable |

## Verification
The bench targets the cases where an address could change early or late. One case changes the parallel pins after a latched load; a design that still tracked the pins would lose the captured value. Another checks the address in the middle of a serial write; a design that committed on each shift would expose partial values. The bench also toggles the serial clock with the enable low, where a design that shifted anyway would corrupt the readback. Readback order, the 16-bit cascade and the reading of a parallel value through the serial port each catch designs with reversed bit order, a missing serial output stage, or separate registers per mode.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/dly_pin_sync.sv
module dly_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dly_in_shreg.sv
module dly_in_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/dly_prog_if.sv
module dly_prog_if
  import dly_prog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] par_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int SW = ADDR_W + 4;

  logic [SW-1:0]     pins_s;
  logic              mode_s, en_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] par_s;
  logic              en_d, sclk_d;
  logic              en_fall, sclk_rise, ser;
  logic              ld_par, sh_en;
  logic [ADDR_W-1:0] shq;

  dly_pin_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mode_i, en_i, sclk_i, sdi_i, par_i}),
    .q   (pins_s)
  );

  assign {mode_s, en_s, sclk_s, sdi_s, par_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
    end
  end

  assign en_fall   = en_d & ~en_s;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign ser       = (prog_mode_e'(mode_s) == MODE_SERIAL);
  assign ld_par    = ~ser & (en_s | en_fall);
  assign sh_en     = ser & en_s & sclk_rise;

  dly_in_shreg #(.W(ADDR_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_par),
    .load_val (par_s),
    .shift    (sh_en),
    .sin      (sdi_s),
    .q        (shq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o   <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (ld_par)              addr_o <= par_s;
      else if (ser && en_fall) addr_o <= shq;
      sdo_oe_o <= ser & en_s;
      sdo_o    <= (ser & en_s) ? shq[ADDR_W-1] : 1'b0;
    end
  end
endmodule

// File: rtl/dly_prog_chk.sv
module dly_prog_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_s,
  input logic              en_s,
  input logic              en_fall,
  input logic [ADDR_W-1:0] par_s,
  input logic [ADDR_W-1:0] shq,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sdo_o,
  input logic              sdo_oe_o
);
  a_r2_follow_pins: assert property (@(posedge clk) disable iff (rst)
    (mode_s && en_s) |=> (addr_o == $past(par_s)));

  a_r4_hold_while_shifting: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !en_fall) |=> $stable(addr_o));

  a_r5_commit_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && en_fall) |=> (addr_o == $past(shq)));

  a_r10_oe_off: assert property (@(posedge clk) disable iff (rst)
    (mode_s || !en_s) |=> !sdo_oe_o);

  a_r10_quiet_sdo: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe_o |-> !sdo_o);
endmodule

bind dly_prog_if dly_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_s   (mode_s),
  .en_s     (en_s),
  .en_fall  (en_fall),
  .par_s    (par_s),
  .shq      (shq),
  .addr_o   (addr_o),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/tb_dly_prog_if.sv
module tb_dly_prog_if;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NV = 6;
  localparam logic [AW-1:0] PVEC [NV] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80};

  logic clk = 1'b0, rst = 1'b1;
  logic mode_i = 1'b0, en_i = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
  logic [AW-1:0] par_i = '0;
  logic [AW-1:0] addr_o;
  logic sdo_o, sdo_oe_o;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;
  logic [AW-1:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_prog_if #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .en_i(en_i), .par_i(par_i),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .addr_o(addr_o), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Shift one byte MSB first; return the bits seen on sdo before each rising clock.
  task automatic shift_byte(input logic [AW-1:0] b, output logic [AW-1:0] seen);
    for (int i = AW-1; i >= 0; i--) begin
      sdi_i = b[i];
      wcyc(6);
      seen[i] = sdo_o;
      sclk_i = 1'b1;
      wcyc(6);
      sclk_i = 1'b0;
      wcyc(6);
    end
  endtask

  initial begin
    wcyc(5);
    rst = 1'b0;
    wcyc(8);
    chk("R1 addr", addr_o, 8'h00);
    chk("R1 sdo", {7'b0, sdo_o}, 8'h00);
    chk("R1 oe", {7'b0, sdo_oe_o}, 8'h00);

    // R2: transparent parallel vectors
    mode_i = 1'b1; en_i = 1'b1;
    for (int k = 0; k < NV; k++) begin
      par_i = PVEC[k];
      wcyc(8);
      chk("R2 transparent", addr_o, PVEC[k]);
      chk("R10 oe off in parallel", {7'b0, sdo_oe_o}, 8'h00);
    end

    // R3: latched parallel
    par_i = 8'h3C; wcyc(8);
    en_i = 1'b0; wcyc(8);
    chk("R3 latched", addr_o, 8'h3C);
    par_i = 8'hC3; wcyc(8);
    chk("R3 pins ignored", addr_o, 8'h3C);
    en_i = 1'b1; wcyc(8); en_i = 1'b0; wcyc(8);
    chk("R3 second pulse", addr_o, 8'hC3);

    // R11, R6, R4, R5: serial read of parallel value, write new
    mode_i = 1'b0; wcyc(8);
    chk("R10 oe off en low", {7'b0, sdo_oe_o}, 8'h00);
    en_i = 1'b1; wcyc(8);
    chk("R10 oe on", {7'b0, sdo_oe_o}, 8'h01);
    shift_byte(8'h96, got);
    chk("R11 readback of parallel load", got, 8'hC3);
    chk("R4 addr held before fall", addr_o, 8'hC3);
    en_i = 1'b0; wcyc(8);
    chk("R5 commit on fall", addr_o, 8'h96);

    // R7: clocks with enable low are ignored
    sdi_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sclk_i = 1'b1; wcyc(6); sclk_i = 1'b0; wcyc(6);
    end
    chk("R7 addr unchanged", addr_o, 8'h96);
    en_i = 1'b1; wcyc(8);
    shift_byte(8'h96, got);
    chk("R7/R6 readback", got, 8'h96);
    en_i = 1'b0; wcyc(8);
    chk("R9 writeback keeps setting", addr_o, 8'h96);

    // R8: cascade through a single device
    en_i = 1'b1; wcyc(8);
    shift_byte(8'h11, got);
    chk("R8 first byte out", got, 8'h96);
    shift_byte(8'h22, got);
    chk("R8 cascade byte out", got, 8'h11);
    en_i = 1'b0; wcyc(8);
    chk("R8 last byte kept", addr_o, 8'h22);

    // R9: read without writeback
    en_i = 1'b1; wcyc(8);
    shift_byte(8'h00, got);
    chk("R9 read value", got, 8'h22);
    en_i = 1'b0; wcyc(8);
    chk("R9 destructive", addr_o, 8'h00);
    chk("R10 sdo low", {7'b0, sdo_o}, 8'h00);

    // R1: reset mid-operation
    mode_i = 1'b1; en_i = 1'b1; par_i = 8'h77; wcyc(8);
    rst = 1'b1; wcyc(2);
    chk("R1 reset clears", addr_o, 8'h00);
    rst = 1'b0; wcyc(8);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule